// File: doc/BRIEF.md
# Complementary PWM with Dead Time and Burst Control

This block is a pulse-width modulator that drives two complementary outputs for a half-bridge or a pair of alternating loads. A free-running period counter splits each PWM period into a primary phase and a secondary phase. A dead-time stage delays the rising edge of each output, so that both outputs rest inactive for a programmed number of clocks around every hand-over. A kill input stops everything on the next clock edge. The counter width is a parameter, and the 8-bit and 16-bit variants are the same RTL.

Runs always begin with a start pulse. The run mode sets how long a run lasts. Continuous mode runs until kill. One-shot mode runs a single period. Multi-shot mode runs a programmed number of periods and then returns to idle, and a later start repeats the whole burst. The controller has three named states. IDLE holds the counter at zero. RUN counts periods. HALT is entered from any state when kill is seen and is held while kill stays high. The transitions are: IDLE->RUN on start (when not killed and not disabled); RUN->IDLE when the final period of a burst wraps; IDLE->HALT and RUN->HALT on kill; HALT->IDLE when kill is released.

Top module: `pwmdb_top`

## Requirements
- R1: After reset, both outputs are low and the block is idle.
- R2: A period lasts `period`+1 clocks. The primary phase covers counter values below `compare`. With dead time `dead` < `compare`, `out_a` is high for `compare`-`dead` clocks in each period, and it rises `dead`+1 clocks after its phase begins.
- R3: `out_b` is driven from the remaining `period`+1-`compare` counter values and has the same rising-edge delay. `out_a` and `out_b` are never high in the same cycle.
- R4: When `dead` is equal to or greater than the length of a phase, that output stays low for the whole phase and produces no pulse.
- R5: In multi-shot mode (`mode` = 2'b10), a start runs exactly `shots` periods, with a value of 0 treated as 1. Both outputs are then low until the next start.
- R6: In one-shot mode (`mode` = 2'b01), a start runs exactly one period whatever `shots` holds.
- R7: In continuous mode (`mode` = 2'b00), a start begins periods that repeat without end until kill.
- R8: A start that arrives while a run is in progress is ignored. A start after a burst has ended runs the full burst again.
- R9: When `kill` is high at a clock edge, both outputs are low after that edge and any run is aborted. The block stays idle after kill falls, until a new start arrives.
- R10: When `start` and `kill` are high at the same edge, kill wins and no run begins.
- R11: With `mode` = 2'b11 (disabled), start is ignored and the outputs stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 00 continuous, 01 one-shot, 10 multi-shot, 11 disabled |
| period | input | CW | Last counter value of a period |
| compare | input | CW | Primary phase covers counter values below this |
| dead | input | CW | Rising-edge delay in clocks |
| shots | input | SW | Periods per multi-shot burst (0 means 1) |
| start | input | 1 | Begins a run when idle |
| kill | input | 1 | Forces both outputs low and aborts the run |
| out_a | output | 1 | Primary output |
| out_b | output | 1 | Secondary (complementary) output |

## Verification
Kill and start can fall on the same edge, both while the block is idle and while a burst is running. Kill must win in both cases. The bench raises start and kill together on one negative edge, then releases kill and watches both outputs for many periods; any output activity is a failure. A second collision comes from a start pulse in the middle of a burst. The bench judges it by counting the primary output's high cycles over the whole burst against the count for the programmed number of periods.

// File: rtl/pwmdb_pkg.sv
package pwmdb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HALT = 2'd2
    } pwm_state_e;

    localparam logic [1:0] MODE_CONT  = 2'b00;
    localparam logic [1:0] MODE_ONE   = 2'b01;
    localparam logic [1:0] MODE_MULTI = 2'b10;
    localparam logic [1:0] MODE_OFF   = 2'b11;

    localparam int NUM_CH = 2;

endpackage

// File: rtl/pwmdb_ctrl.sv
module pwmdb_ctrl
    import pwmdb_pkg::*;
#(
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode,
    input  logic [SW-1:0] shots,
    input  logic          start,
    input  logic          kill,
    input  logic          wrap,
    output logic          run
);

    localparam logic [SW-1:0] REM_ONE = SW'(1);

    pwm_state_e    state_q, state_d;
    logic [SW-1:0] remain_q, remain_d;
    logic          last_period;

    assign last_period = (mode == MODE_ONE) || (remain_q <= REM_ONE);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            remain_q <= '0;
        end else begin
            state_q  <= state_d;
            remain_q <= remain_d;
        end
    end

    // next state and burst counter
    always_comb begin
        state_d  = state_q;
        remain_d = remain_q;
        unique case (state_q)
            ST_IDLE: begin
                if (kill) begin
                    state_d = ST_HALT;
                end else if (start && (mode != MODE_OFF)) begin
                    state_d  = ST_RUN;
                    remain_d = (shots == '0) ? REM_ONE : shots;
                end
            end
            ST_RUN: begin
                if (kill) begin
                    state_d = ST_HALT;
                end else if (wrap && (mode != MODE_CONT)) begin
                    if (last_period) begin
                        state_d = ST_IDLE;
                    end else begin
                        remain_d = remain_q - REM_ONE;
                    end
                end
            end
            ST_HALT: begin
                if (!kill) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        run = (state_q == ST_RUN);
    end

    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && start && !kill && !wrap) |=> (state_q == ST_RUN && $stable(remain_q)));

    assert_halt_no_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT) |=> (state_q != ST_RUN));

    assert_kill_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (kill && start) |=> (state_q == ST_HALT));

    assert_one_shot_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && wrap && !kill && mode == MODE_ONE) |=> (state_q == ST_IDLE));

    assert_disabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && mode == MODE_OFF) |=> (state_q != ST_RUN));

endmodule

// File: rtl/pwmdb_counter.sv
module pwmdb_counter #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] period,
    input  logic [CW-1:0] compare,
    output logic          phase_a,
    output logic          phase_b,
    output logic          wrap
);

    logic [CW-1:0] cnt_q;
    logic          below;

    assign below   = (cnt_q < compare);
    assign wrap    = run && (cnt_q == period);
    assign phase_a = run && below;
    assign phase_b = run && !below;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || wrap) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assert_wrap_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt_q == '0));

endmodule

// File: rtl/pwmdb_deadband.sv
module pwmdb_deadband #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          level,
    input  logic          force_off,
    input  logic [CW-1:0] dead,
    output logic          out
);

    logic [CW-1:0] dly_q;
    logic          out_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dly_q <= '0;
            out_q <= 1'b0;
        end else if (force_off || !level) begin
            dly_q <= '0;
            out_q <= 1'b0;
        end else if (dly_q >= dead) begin
            out_q <= 1'b1;
        end else begin
            dly_q <= dly_q + CW'(1);
            out_q <= 1'b0;
        end
    end

    assign out = out_q;

    assert_rise_after_dead_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_q) |-> ($past(level) && ($past(dly_q) >= $past(dead))));

endmodule

// File: rtl/pwmdb_top.sv
module pwmdb_top
    import pwmdb_pkg::*;
#(
    parameter int CW = 8,
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode,
    input  logic [CW-1:0] period,
    input  logic [CW-1:0] compare,
    input  logic [CW-1:0] dead,
    input  logic [SW-1:0] shots,
    input  logic          start,
    input  logic          kill,
    output logic          out_a,
    output logic          out_b
);

    logic              run;
    logic              wrap;
    logic [NUM_CH-1:0] lv;
    logic [NUM_CH-1:0] drv;

    pwmdb_ctrl #(.SW(SW)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (mode),
        .shots (shots),
        .start (start),
        .kill  (kill),
        .wrap  (wrap),
        .run   (run)
    );

    pwmdb_counter #(.CW(CW)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .period  (period),
        .compare (compare),
        .phase_a (lv[0]),
        .phase_b (lv[1]),
        .wrap    (wrap)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        pwmdb_deadband #(.CW(CW)) u_db (
            .clk       (clk),
            .rst_n     (rst_n),
            .level     (lv[ch]),
            .force_off (kill),
            .dead      (dead),
            .out       (drv[ch])
        );
    end

    assign out_a = drv[0];
    assign out_b = drv[1];

    assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_a && out_b));

    assert_kill_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> (!out_a && !out_b));

endmodule

// File: tb/pwmdb_top_test.sv
`timescale 1ns/1ps
module pwmdb_top_test;

    localparam int CW = 8;
    localparam int SW = 8;
    localparam int NV = 6;

    // mode, period, compare, dead, shots, expected A highs, B highs, A rises
    localparam int V_MODE[NV] = '{2, 1, 2, 2, 2, 2};
    localparam int V_PER [NV] = '{9, 7, 5, 5, 11, 4};
    localparam int V_CMP [NV] = '{4, 4, 2, 3, 6, 1};
    localparam int V_DT  [NV] = '{1, 2, 2, 0, 3, 5};
    localparam int V_N   [NV] = '{5, 3, 3, 2, 0, 4};
    localparam int V_EA  [NV] = '{15, 2, 0, 6, 3, 0};
    localparam int V_EB  [NV] = '{25, 2, 6, 6, 3, 0};
    localparam int V_RA  [NV] = '{5, 1, 0, 2, 1, 0};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    mode = 2'b00;
    logic [CW-1:0] period = '0;
    logic [CW-1:0] compare = '0;
    logic [CW-1:0] dead = '0;
    logic [SW-1:0] shots = '0;
    logic          start = 1'b0;
    logic          kill = 1'b0;
    logic          out_a, out_b;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    always #2 clk = ~clk;

    pwmdb_top #(.CW(CW), .SW(SW)) uut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .period(period),
        .compare(compare), .dead(dead), .shots(shots),
        .start(start), .kill(kill), .out_a(out_a), .out_b(out_b)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
            $finish;
        end
    end

    task automatic check_eq(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic setup(input int m, input int p, input int c, input int d, input int n);
        @(negedge clk);
        mode    = 2'(m);
        period  = CW'(p);
        compare = CW'(c);
        dead    = CW'(d);
        shots   = SW'(n);
    endtask

    task automatic fire();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    // observe outputs; optionally pulse start again at sample restart_at
    task automatic observe(input int cycles, input int restart_at,
                           output int ha, output int hb, output int ra, output int ov);
        logic prev = 1'b0;
        ha = 0; hb = 0; ra = 0; ov = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            start = (i == restart_at);
            if (out_a) ha++;
            if (out_b) hb++;
            if (out_a && !prev) ra++;
            if (out_a && out_b) ov++;
            prev = out_a;
        end
        start = 1'b0;
    endtask

    initial begin
        int ha, hb, ra, ov;

        // R1 reset state
        repeat (3) @(negedge clk);
        check_eq("R1 out_a in reset", int'(out_a), 0);
        check_eq("R1 out_b in reset", int'(out_b), 0);
        rst_n = 1'b1;
        observe(10, -1, ha, hb, ra, ov);
        check_eq("R1 idle after reset", ha + hb, 0);

        // vector table: R2..R6
        for (int v = 0; v < NV; v++) begin
            setup(V_MODE[v], V_PER[v], V_CMP[v], V_DT[v], V_N[v]);
            fire();
            observe(90, -1, ha, hb, ra, ov);
            check_eq($sformatf("R2 R5 R6 vec%0d out_a high cycles", v), ha, V_EA[v]);
            check_eq($sformatf("R3 R4 vec%0d out_b high cycles", v), hb, V_EB[v]);
            check_eq($sformatf("R5 R6 vec%0d primary pulses", v), ra, V_RA[v]);
            check_eq($sformatf("R3 vec%0d overlap cycles", v), ov, 0);
            check_eq($sformatf("R5 vec%0d outputs idle after burst", v), int'(out_a | out_b), 0);
        end

        // R7 continuous mode keeps running
        setup(0, 9, 4, 1, 1);
        fire();
        observe(100, -1, ha, hb, ra, ov);
        check_eq("R7 continuous primary pulses in 100 clocks", ra, 10);
        check_eq("R3 continuous overlap", ov, 0);

        // R9 kill stops on the next edge and needs a fresh start
        @(negedge clk) kill = 1'b1;
        @(negedge clk);
        check_eq("R9 outputs low one edge after kill", int'(out_a | out_b), 0);
        repeat (3) @(negedge clk);
        kill = 1'b0;
        observe(40, -1, ha, hb, ra, ov);
        check_eq("R9 no restart after kill release", ha + hb, 0);

        // R9 kill aborts a multi-shot burst in progress
        setup(2, 9, 4, 1, 5);
        fire();
        observe(15, -1, ha, hb, ra, ov);
        @(negedge clk) kill = 1'b1;
        @(negedge clk) kill = 1'b0;
        observe(80, -1, ha, hb, ra, ov);
        check_eq("R9 burst aborted by kill", ha + hb, 0);
        fire();
        observe(90, -1, ha, hb, ra, ov);
        check_eq("R9 full burst after new start", ha, 15);

        // R8 start during a burst is ignored, later start repeats
        setup(2, 9, 4, 1, 2);
        fire();
        observe(60, 5, ha, hb, ra, ov);
        check_eq("R8 restart mid-burst ignored", ha, 6);
        fire();
        observe(60, -1, ha, hb, ra, ov);
        check_eq("R8 later start repeats burst", ha, 6);

        // R10 start and kill on the same edge
        @(negedge clk) begin start = 1'b1; kill = 1'b1; end
        @(negedge clk) begin start = 1'b0; kill = 1'b0; end
        observe(40, -1, ha, hb, ra, ov);
        check_eq("R10 kill beats simultaneous start", ha + hb, 0);

        // R11 disabled mode ignores start
        setup(3, 9, 4, 1, 2);
        fire();
        observe(40, -1, ha, hb, ra, ov);
        check_eq("R11 disabled mode stays low", ha + hb, 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule